// File: doc/BRIEF.md
# Toggle-Bit Completion Status Poller

This block decides when an embedded program or erase operation inside a parallel NOR flash has finished, and whether it succeeded. After a `start` pulse it reads the target address twice in a row. It compares the toggle bit of the older read with that of the newer read, and it checks the timeout bit of the newer read. In datum-checking mode it also compares the newer read with the expected word. If the part is still busy, it waits a programmable number of idle cycles and reads another pair. A cycle-count watchdog, loaded at `start`, limits the whole wait.

A poll can end with the toggle bit still moving while the device timeout bit is set. In that case the block takes one extra pair of reads. If that pair agrees, the operation finished late but correctly. If the pair still differs, the block writes a reset command to the device base address and reports a device timeout. The result is a one-cycle `done` pulse and a 2-bit `status` code.

The bus is split into byte lanes, so that interleaved devices on a wide bus are judged lane by lane. Each lane has its own parameterized toggle and timeout bit positions.

Top module: `tbit_poller`

## Requirements
- R1: After reset, `done`, `rd_req` and `wr_req` are low and `status` is 0.
- R2: Each poll iteration issues two reads back to back, `rd_req` staying high between them. Every read uses the `target_addr` latched at `start`.
- R3: With datum checking off, polling ends with `status` 0 (ok) on the first pair whose bit 6 is equal in every lane.
- R4: With `check_datum` high, polling continues while the newer read differs from `expected`, even with no toggling. It ends with status 0 once they match. If they never match, the watchdog ends it with status 3.
- R5: A lane whose bit 6 differs and whose newer bit 5 is clear keeps polling. If this is still so when the watchdog expires, `status` is 3 (watchdog timeout) and no write is issued.
- R6: If polling stops with bit 6 still differing in some lane, and every such lane has bit 5 set in the newer read, exactly one more pair is read. If that pair is equal, `status` is 1 (ok with warning) and no write is issued.
- R7: If that extra pair differs, `wr_req` pulses for one cycle with `wr_addr` equal to `base_addr` and `wr_data` equal to 0xF0 in every byte lane. On the next cycle `done` rises with `status` 2 (device timeout).
- R8: Between the last read of one pair and the first read of the next, `rd_req` is low for exactly `gap_cycles` + 1 cycles.
- R9: Lanes are judged independently. One lane polling with bit 5 clear forces status 3, even when another toggling lane has bit 5 set.
- R10: `done` is high for exactly one cycle per operation. A `start` pulse during an operation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| check_datum | input | 1 | Also require the newer read to equal `expected` |
| expected | input | DATA_W | Expected final word |
| gap_cycles | input | GAP_W | Idle cycles between poll iterations |
| target_addr | input | ADDR_W | Address that is polled |
| base_addr | input | ADDR_W | Device base address for the reset command |
| rd_req | output | 1 | Read request, held until `rd_valid` |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | DATA_W | Read data |
| wr_req | output | 1 | One-cycle reset-command write |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 ok with warning, 2 device timeout, 3 watchdog timeout |

## Verification
The bench goes after the split between a late-good completion and a real device timeout. A design that skips the extra pair would report a device timeout, or reset a part that had in fact finished. A design that checks the timeout bit in the wrong read would enter the recheck on a lane that is still busy.

It mixes lanes so that a single busy lane must override another lane that is already timing out. A design that merges lanes before deciding would enter the recheck instead of reporting a watchdog timeout.

It measures the idle run between pairs, which catches a gap counter that is off by one. It also checks datum mode with a non-toggling wrong value, which a design that only looks at bit 6 would accept too early.

// File: rtl/tbit_poller_pkg.sv
package tbit_poller_pkg;
  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_WARN = 2'd1,
    ST_DEV  = 2'd2,
    ST_WD   = 2'd3
  } poll_status_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_OLD, S_RD_NEW, S_EVAL, S_GAP,
    S_RE_OLD, S_RE_NEW, S_RE_EVAL, S_RST_WR
  } poll_state_t;
endpackage

// File: rtl/tbit_lane.sv
module tbit_lane #(
  parameter int LANE_W  = 8,
  parameter int TOG_POS = 6,
  parameter int TMO_POS = 5
) (
  input  logic [LANE_W-1:0] older,
  input  logic [LANE_W-1:0] newer,
  output logic              toggling,
  output logic              tmo_flag
);
  always_comb begin
    toggling = older[TOG_POS] ^ newer[TOG_POS];
    tmo_flag = newer[TMO_POS];
  end
endmodule

// File: rtl/tbit_watchdog.sv
module tbit_watchdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= CW'(LIMIT);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_WD_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT)); // R5

  AST_WD_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == CW'(LIMIT))); // R5
endmodule

// File: rtl/tbit_poller.sv
module tbit_poller
  import tbit_poller_pkg::*;
#(
  parameter int LANES    = 1,
  parameter int LANE_W   = 8,
  parameter int ADDR_W   = 24,
  parameter int GAP_W    = 8,
  parameter int WD_LIMIT = 1000,
  parameter logic [LANES*8-1:0] TOG_POS = {LANES{8'd6}},
  parameter logic [LANES*8-1:0] TMO_POS = {LANES{8'd5}},
  parameter logic [LANE_W-1:0]  RST_CMD = LANE_W'(8'hF0),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              check_datum,
  input  logic [DATA_W-1:0] expected,
  input  logic [GAP_W-1:0]  gap_cycles,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done,
  output logic [1:0]        status
);
  poll_state_t       state;
  logic [DATA_W-1:0] older_q, newer_q, datum_q;
  logic              chk_q;
  logic [GAP_W-1:0]  gap_q, gap_cnt;
  logic [LANES-1:0]  tog_v, tmo_v, lane_busy;
  logic              mismatch, still_busy, wd_expired, wd_load;

  assign wd_load = start && (state == S_IDLE);

  tbit_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk(clk), .rst(rst), .load(wd_load), .expired(wd_expired)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tbit_lane #(
      .LANE_W (LANE_W),
      .TOG_POS(int'(TOG_POS[8*i +: 8])),
      .TMO_POS(int'(TMO_POS[8*i +: 8]))
    ) u_lane (
      .older   (older_q[LANE_W*i +: LANE_W]),
      .newer   (newer_q[LANE_W*i +: LANE_W]),
      .toggling(tog_v[i]),
      .tmo_flag(tmo_v[i])
    );
  end

  always_comb begin
    lane_busy  = tog_v & ~tmo_v;
    mismatch   = chk_q && (newer_q != datum_q);
    still_busy = (|lane_busy) || mismatch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
      status  <= ST_OK;
      older_q <= '0;
      newer_q <= '0;
      datum_q <= '0;
      chk_q   <= 1'b0;
      gap_q   <= '0;
      gap_cnt <= '0;
    end else begin
      done   <= 1'b0;
      wr_req <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          datum_q <= expected;
          chk_q   <= check_datum;
          gap_q   <= gap_cycles;
          rd_addr <= target_addr;
          wr_addr <= base_addr;
          rd_req  <= 1'b1;
          state   <= S_RD_OLD;
        end
        S_RD_OLD: if (rd_valid) begin
          older_q <= rd_data;
          state   <= S_RD_NEW;
        end
        S_RD_NEW: if (rd_valid) begin
          newer_q <= rd_data;
          rd_req  <= 1'b0;
          state   <= S_EVAL;
        end
        S_EVAL: begin
          if (still_busy && !wd_expired) begin
            if (gap_q == '0) begin
              rd_req <= 1'b1;
              state  <= S_RD_OLD;
            end else begin
              gap_cnt <= gap_q;
              state   <= S_GAP;
            end
          end else if (|lane_busy) begin
            done   <= 1'b1;
            status <= ST_WD;
            state  <= S_IDLE;
          end else if (|tog_v) begin
            rd_req <= 1'b1;
            state  <= S_RE_OLD;
          end else begin
            done   <= 1'b1;
            status <= mismatch ? ST_WD : ST_OK;
            state  <= S_IDLE;
          end
        end
        S_GAP: begin
          gap_cnt <= gap_cnt - 1'b1;
          if (gap_cnt == GAP_W'(1)) begin
            rd_req <= 1'b1;
            state  <= S_RD_OLD;
          end
        end
        S_RE_OLD: if (rd_valid) begin
          older_q <= rd_data;
          state   <= S_RE_NEW;
        end
        S_RE_NEW: if (rd_valid) begin
          newer_q <= rd_data;
          rd_req  <= 1'b0;
          state   <= S_RE_EVAL;
        end
        S_RE_EVAL: begin
          if (older_q == newer_q) begin
            done   <= 1'b1;
            status <= ST_WARN;
            state  <= S_IDLE;
          end else begin
            wr_req  <= 1'b1;
            wr_data <= {LANES{RST_CMD}};
            state   <= S_RST_WR;
          end
        end
        S_RST_WR: begin
          done   <= 1'b1;
          status <= ST_DEV;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_req); // R2

  AST_WR_THEN_DEV: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> (done && status == ST_DEV)); // R7

  AST_DEV_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    (done && status == ST_DEV) |-> $past(wr_req)); // R7

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !wr_req); // R7

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (rd_req && $past(rd_req)) |-> $stable(rd_addr)); // R2
endmodule

// File: tb/sim_tbit_poller.sv
module sim_tbit_poller;
  localparam int LANES = 2;
  localparam int DW    = 16;
  localparam int AW    = 24;
  localparam int GW    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0, check_datum = 1'b0;
  logic [DW-1:0] expected = '0;
  logic [GW-1:0] gap_cycles = '0;
  logic [AW-1:0] target_addr = 24'h001234, base_addr = 24'h001000;
  logic          rd_req, rd_valid = 1'b0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data = '0, wr_data;
  logic          wr_req, done;
  logic [1:0]    status;

  always #10 clk = ~clk;

  tbit_poller #(.LANES(LANES), .ADDR_W(AW), .GAP_W(GW), .WD_LIMIT(300)) u0 (
    .clk(clk), .rst(rst), .start(start), .check_datum(check_datum),
    .expected(expected), .gap_cycles(gap_cycles), .target_addr(target_addr),
    .base_addr(base_addr), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .status(status)
  );

  int tests = 0, fails = 0;

  // flash model settings
  int            k = 0;
  int            busy_reads = 0;
  logic [7:0]    busy_byte = 8'h00;
  logic [1:0]    tog_mask = 2'b11, b5_mask = 2'b00;
  logic [DW-1:0] final_word = '0;

  function automatic logic [DW-1:0] model(int idx);
    logic [DW-1:0] w;
    if (idx >= busy_reads) return final_word;
    for (int l = 0; l < LANES; l++) begin
      logic [7:0] b;
      b = busy_byte;
      if (tog_mask[l]) b[6] = idx[0];
      if (b5_mask[l])  b[5] = 1'b1;
      w[8*l +: 8] = b;
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (rd_req && !rd_valid) begin
      rd_data  <= model(k);
      k        <= k + 1;
      rd_valid <= 1'b1;
    end else rd_valid <= 1'b0;
  end

  typedef struct { int st; int reads; int wrs; string req; } exp_t;
  exp_t q[$];
  int   reads_seen = 0, wrs_seen = 0, run = 0, exp_gap = -1;
  bit   prev_done = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_req && rd_valid) begin
        reads_seen++;
        if (rd_addr != target_addr) check(0, "R2", "rd_addr", int'(rd_addr), int'(target_addr));
      end
      if (reads_seen > 0 && !rd_req) run++;
      else if (rd_req && run > 0) begin
        if (exp_gap >= 0) check(run == exp_gap, "R8", "idle run", run, exp_gap);
        run = 0;
      end
      if (wr_req) begin
        wrs_seen++;
        check(wr_addr == base_addr, "R7", "wr_addr", int'(wr_addr), int'(base_addr));
        check(wr_data == 16'hF0F0, "R7", "wr_data", int'(wr_data), 16'hF0F0);
      end
      if (done && prev_done) check(0, "R10", "done width", 2, 1);
      if (done) begin
        exp_t e;
        if (q.size() == 0) check(0, "R10", "unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          check(int'(status) == e.st, e.req, "status", int'(status), e.st);
          if (e.reads >= 0) check(reads_seen == e.reads, e.req, "reads", reads_seen, e.reads);
          check(wrs_seen == e.wrs, e.req, "writes", wrs_seen, e.wrs);
        end
        reads_seen = 0; wrs_seen = 0; run = 0;
      end
      prev_done = done;
    end
  end

  task automatic run_op(string req, int st, int reads, int wrs, int gap,
                        bit chk, bit extra_start);
    exp_t e;
    e.st = st; e.reads = reads; e.wrs = wrs; e.req = req;
    q.push_back(e);
    @(negedge clk);
    k = 0; exp_gap = gap + 1; gap_cycles = GW'(gap); check_datum = chk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(done == 0, "R1", "done", int'(done), 0);
    check(rd_req == 0, "R1", "rd_req", int'(rd_req), 0);
    check(wr_req == 0, "R1", "wr_req", int'(wr_req), 0);
    check(status == 0, "R1", "status", int'(status), 0);

    // R3: three toggling pairs then stable, gap 0
    busy_reads = 6; tog_mask = 2'b11; b5_mask = 2'b00; busy_byte = 8'h00; final_word = 16'h0000;
    run_op("R3", 0, 8, 0, 0, 1'b0, 1'b0);
    // R8: same with gap 3
    run_op("R8", 0, 8, 0, 3, 1'b0, 1'b0);
    // R4: non-toggling wrong value then match
    busy_reads = 4; tog_mask = 2'b00; busy_byte = 8'h11; final_word = 16'h3C3C; expected = 16'h3C3C;
    run_op("R4", 0, 6, 0, 0, 1'b1, 1'b0);
    // R4: never matches -> watchdog
    busy_reads = 100000; expected = 16'h5A5A;
    run_op("R4", 3, -1, 0, 2, 1'b1, 1'b0);
    // R6: toggling with bit5 set, late good finish
    busy_reads = 2; tog_mask = 2'b11; b5_mask = 2'b11; busy_byte = 8'h00; final_word = 16'h0000;
    run_op("R6", 1, 4, 0, 0, 1'b0, 1'b0);
    // R7: still toggling on recheck -> reset write
    busy_reads = 100000;
    run_op("R7", 2, 4, 1, 0, 1'b0, 1'b0);
    // R5: toggling with bit5 clear -> watchdog
    b5_mask = 2'b00;
    run_op("R5", 3, -1, 0, 2, 1'b0, 1'b0);
    // R9: only lane 1 toggles, then settles
    busy_reads = 4; tog_mask = 2'b10;
    run_op("R9", 0, 6, 0, 0, 1'b0, 1'b0);
    // R9: lane 0 timing out, lane 1 still busy -> watchdog, no recheck
    busy_reads = 100000; tog_mask = 2'b11; b5_mask = 2'b01;
    run_op("R9", 3, -1, 0, 0, 1'b0, 1'b0);
    // R10: start during operation ignored
    busy_reads = 6; tog_mask = 2'b11; b5_mask = 2'b00;
    run_op("R10", 0, 8, 0, 0, 1'b0, 1'b1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule